// File: doc/BRIEF.md
# Resume Wake-Event Hold Timer

This block holds the system awake for a set time after a secondary wake event arrives while the system is suspended. A wake strobe arms the timer when the enable input is high. The activity flag then stays high until the hold period runs out. At that point the block raises a one-clock expiry pulse, which a suspend controller can use to decide whether to go back to sleep.

A 2-bit select picks the hold period. Three codes give fixed periods of 2 ms, 64 ms and 1 s. The fourth code ties the period to interrupt handling instead: the timer waits for an end-of-interrupt (EOI) strobe, then expires 0.25 ms later.

All periods are whole multiples of a 0.25 ms unit. An internal prescaler derives this unit from the clock, using the `UNIT_CYCLES` parameter. A further wake strobe before expiry always starts the hold over from the beginning. Dropping the enable input aborts the hold at once, with no expiry pulse.

Top module: `resume_event_timer`

## Requirements
- R1: After reset, `evt_active` and `expire_pulse` are both 0.
- R2: While `tmr_en` is 0, a `wake_evt` strobe has no effect: `evt_active` stays 0 and no `expire_pulse` follows.
- R3: With `dur_sel` = 2'b00, a wake strobe sampled at clock edge E raises `evt_active` from edge E. `expire_pulse` is high in the cycle after edge E + 8·UNIT_CYCLES (2 ms).
- R4: With `dur_sel` = 2'b01, expiry follows at edge E + 256·UNIT_CYCLES (64 ms).
- R5: With `dur_sel` = 2'b10, expiry follows at edge E + 4000·UNIT_CYCLES (1 s).
- R6: With `dur_sel` = 2'b11, the timer stays active with no expiry until an EOI strobe is sampled at edge F. Expiry then follows at edge F + UNIT_CYCLES (0.25 ms).
- R7: A wake strobe during a fixed-period hold restarts the full period, using the `dur_sel` value present at the new strobe.
- R8: In EOI mode, a wake strobe before expiry, including during the 0.25 ms after EOI, returns the timer to waiting for a new EOI.
- R9: `expire_pulse` is high for exactly one cycle, and `evt_active` is 0 from the edge that raises it.
- R10: Sampling `tmr_en` = 0 during a hold clears `evt_active` at that edge, and no `expire_pulse` follows.
- R11: An EOI strobe is ignored unless the timer is waiting for one. This holds while idle and during a fixed-period hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_en | input | 1 | Timer enable; 0 aborts and blocks arming |
| dur_sel | input | 2 | Hold period select: 00 2 ms, 01 64 ms, 10 1 s, 11 EOI + 0.25 ms |
| wake_evt | input | 1 | Secondary wake event strobe |
| eoi_strobe | input | 1 | End-of-interrupt strobe |
| evt_active | output | 1 | High while a wake event is held and the timer runs |
| expire_pulse | output | 1 | One-clock pulse when the hold period ends |

## Verification
Each of the four select codes is armed alone and run to expiry. This shows whether the period decode and the prescaler scaling are right for each code, to the exact cycle. Restart patterns re-strobe the wake input partway through a fixed hold and partway through an EOI hold. These show whether the counter reloads or keeps running. Stray EOI strobes while idle or during a fixed hold show whether EOI leaks into the wrong mode. Wake strobes with the enable low, and an enable drop in mid-count, show the difference between ignoring an event and aborting a hold.

// File: rtl/rset_pkg.sv
package rset_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_EOI = 2'd1,
    ST_COUNT    = 2'd2
  } rset_state_e;

  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_EOI   = 2'b11
  } rset_sel_e;

endpackage

// File: rtl/rset_rstsync.sv
module rset_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rset_prescale.sv
module rset_prescale #(
  parameter int UNIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_CYCLES - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;

  always_comb begin
    pre_en = 1'b0;
    pre_d  = pre_q;
    if (restart) begin
      pre_en = 1'b1;
      pre_d  = '0;
    end else if (run) begin
      pre_en = 1'b1;
      pre_d  = (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  assign tick = run && !restart && (pre_q == LAST);

  generate
    if (UNIT_CYCLES > 1) begin : g_gap
      assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("prescaler ticked twice in a row");
    end
  endgenerate

endmodule

// File: rtl/rset_dursel.sv
module rset_dursel #(
  parameter int QUARTERS_PER_MS = 4,
  parameter int SHORT_MS        = 2,
  parameter int MID_MS          = 64,
  parameter int LONG_MS         = 1000,
  parameter int CW              = 12
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] units,
  output logic          is_eoi
);
  import rset_pkg::*;

  localparam logic [CW-1:0] SHORT_U = CW'(SHORT_MS * QUARTERS_PER_MS);
  localparam logic [CW-1:0] MID_U   = CW'(MID_MS * QUARTERS_PER_MS);
  localparam logic [CW-1:0] LONG_U  = CW'(LONG_MS * QUARTERS_PER_MS);

  always_comb begin
    is_eoi = 1'b0;
    unique case (rset_sel_e'(sel))
      SEL_SHORT: units = SHORT_U;
      SEL_MID:   units = MID_U;
      SEL_LONG:  units = LONG_U;
      default: begin
        units  = '0;
        is_eoi = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rset_ctrl.sv
module rset_ctrl #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wake,
  input  logic          eoi,
  input  logic          is_eoi_sel,
  input  logic [CW-1:0] load_units,
  input  logic [CW-1:0] eoi_units,
  input  logic          tick,
  output logic          restart,
  output logic          run,
  output logic          active,
  output logic          expire
);
  import rset_pkg::*;

  rset_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          exp_q, exp_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    exp_d   = 1'b0;
    restart = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
    end else if (wake) begin
      if (is_eoi_sel) begin
        state_d = ST_WAIT_EOI;
      end else begin
        state_d = ST_COUNT;
        cnt_d   = load_units;
        cnt_en  = 1'b1;
        restart = 1'b1;
      end
    end else if (state_q == ST_WAIT_EOI && eoi) begin
      state_d = ST_COUNT;
      cnt_d   = eoi_units;
      cnt_en  = 1'b1;
      restart = 1'b1;
    end else if (state_q == ST_COUNT && tick) begin
      cnt_en = 1'b1;
      if (cnt_q == CW'(1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        exp_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exp_q   <= exp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run    = (state_q == ST_COUNT);
  assign active = (state_q != ST_IDLE);
  assign expire = exp_q;

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ST_IDLE && !exp_q))
    else $error("enable low did not abort the hold");

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q)
    else $error("expiry pulse longer than one cycle");

  assert_pulse_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> state_q == ST_IDLE)
    else $error("still active while expiring");

  assert_eoi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_EOI && en && !eoi) |=> state_q == ST_WAIT_EOI)
    else $error("left EOI wait without a strobe");

  assert_fixed_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wake && !is_eoi_sel) |=> (state_q == ST_COUNT && cnt_q == $past(load_units)))
    else $error("wake did not reload full period");

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wake) |=> state_q == ST_IDLE)
    else $error("left idle without a wake strobe");

endmodule

// File: rtl/resume_event_timer.sv
module resume_event_timer #(
  parameter int UNIT_CYCLES     = 4,
  parameter int QUARTERS_PER_MS = 4,
  parameter int SHORT_MS        = 2,
  parameter int MID_MS          = 64,
  parameter int LONG_MS         = 1000,
  parameter int EOI_QUARTERS    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_en,
  input  logic [1:0] dur_sel,
  input  logic       wake_evt,
  input  logic       eoi_strobe,
  output logic       evt_active,
  output logic       expire_pulse
);

  localparam int CW = $clog2(LONG_MS * QUARTERS_PER_MS + 1);
  localparam logic [CW-1:0] EOI_U = CW'(EOI_QUARTERS);

  logic          rst_sync_n;
  logic [CW-1:0] load_units;
  logic          is_eoi;
  logic          restart, run, tick;

  rset_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rset_dursel #(
    .QUARTERS_PER_MS (QUARTERS_PER_MS),
    .SHORT_MS        (SHORT_MS),
    .MID_MS          (MID_MS),
    .LONG_MS         (LONG_MS),
    .CW              (CW)
  ) u_dur (
    .sel    (dur_sel),
    .units  (load_units),
    .is_eoi (is_eoi)
  );

  rset_prescale #(.UNIT_CYCLES(UNIT_CYCLES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .run     (run),
    .tick    (tick)
  );

  rset_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (tmr_en),
    .wake       (wake_evt),
    .eoi        (eoi_strobe),
    .is_eoi_sel (is_eoi),
    .load_units (load_units),
    .eoi_units  (EOI_U),
    .tick       (tick),
    .restart    (restart),
    .run        (run),
    .active     (evt_active),
    .expire     (expire_pulse)
  );

endmodule

// File: tb/resume_event_timer_test.sv
module resume_event_timer_test;

  localparam int T = 4;

  typedef struct {
    int    due;
    string req;
  } exp_item_t;

  logic       clk;
  logic       rst_n;
  logic       tmr_en;
  logic [1:0] dur_sel;
  logic       wake_evt;
  logic       eoi_strobe;
  logic       evt_active;
  logic       expire_pulse;

  int        cyc = 0;
  int        checks = 0;
  int        errors = 0;
  exp_item_t sb[$];
  logic      prev_exp = 1'b0;

  resume_event_timer #(.UNIT_CYCLES(T)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_en       (tmr_en),
    .dur_sel      (dur_sel),
    .wake_evt     (wake_evt),
    .eoi_strobe   (eoi_strobe),
    .evt_active   (evt_active),
    .expire_pulse (expire_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops the expected expiry when the pulse appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (expire_pulse) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2/R10/R11 unexpected expiry", 1, 0);
        end else begin
          exp_item_t it;
          it = sb.pop_front();
          chk(cyc == it.due, it.req, cyc, it.due);
          chk(evt_active == 1'b0, "R9 active cleared at expiry", int'(evt_active), 0);
        end
        chk(prev_exp == 1'b0, "R9 single-cycle pulse", int'(prev_exp), 0);
      end
      prev_exp = expire_pulse;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 1, 0);
    finish_run();
  end

  // driver: wake strobe, expected expiry pushed when a fixed period applies
  task automatic fire(input logic [1:0] s, input int units, input string req);
    @(negedge clk);
    dur_sel  = s;
    wake_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake_evt = 1'b0;
    if (tmr_en) begin
      sb.delete();
      if (units > 0) sb.push_back('{cyc + units * T, req});
    end
  endtask

  task automatic eoi_pulse(input bit starts, input string req);
    @(negedge clk);
    eoi_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoi_strobe = 1'b0;
    if (starts) begin
      sb.delete();
      sb.push_back('{cyc + T, req});
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(expire_pulse == 1'b0, "R9 pulse dropped", int'(expire_pulse), 0);
    chk(evt_active == 1'b0, "R9 idle after expiry", int'(evt_active), 0);
  endtask

  initial begin
    rst_n = 1'b0; tmr_en = 1'b0; dur_sel = 2'b00; wake_evt = 1'b0; eoi_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(evt_active == 1'b0, "R1 active after reset", int'(evt_active), 0);
    chk(expire_pulse == 1'b0, "R1 expire after reset", int'(expire_pulse), 0);

    // R2: disabled
    fire(2'b00, 8, "R2");
    chk(evt_active == 1'b0, "R2 wake ignored when disabled", int'(evt_active), 0);
    repeat (60) @(negedge clk);
    chk(evt_active == 1'b0, "R2 still idle", int'(evt_active), 0);

    tmr_en = 1'b1;
    // R11: EOI while idle
    eoi_pulse(1'b0, "R11");
    chk(evt_active == 1'b0, "R11 EOI ignored while idle", int'(evt_active), 0);

    // R3
    fire(2'b00, 8, "R3 2ms expiry time");
    chk(evt_active == 1'b1, "R3 active after wake", int'(evt_active), 1);
    drain();

    // R4
    fire(2'b01, 256, "R4 64ms expiry time");
    drain();

    // R5
    fire(2'b10, 4000, "R5 1s expiry time");
    drain();

    // R11: EOI during fixed hold leaves timing unchanged
    fire(2'b00, 8, "R11 fixed hold unaffected by EOI");
    repeat (3) @(negedge clk);
    eoi_pulse(1'b0, "R11");
    drain();

    // R6: EOI mode
    fire(2'b11, 0, "R6");
    repeat (100) @(negedge clk);
    chk(evt_active == 1'b1, "R6 waits for EOI", int'(evt_active), 1);
    chk(sb.size() == 0, "R6 no early expiry", sb.size(), 0);
    eoi_pulse(1'b1, "R6 EOI plus quarter ms");
    drain();

    // R7: restart fixed hold, new select
    fire(2'b01, 256, "R7");
    repeat (20) @(negedge clk);
    fire(2'b00, 8, "R7 restart full period");
    drain();

    // R8: wake during post-EOI count returns to waiting
    fire(2'b11, 0, "R8");
    eoi_pulse(1'b1, "R8");
    fire(2'b11, 0, "R8");
    repeat (30) @(negedge clk);
    chk(evt_active == 1'b1, "R8 waiting again after re-wake", int'(evt_active), 1);
    eoi_pulse(1'b1, "R8 expiry after second EOI");
    drain();

    // R10: abort
    fire(2'b01, 256, "R10");
    repeat (30) @(negedge clk);
    tmr_en = 1'b0;
    sb.delete();
    @(negedge clk);
    chk(evt_active == 1'b0, "R10 abort clears active", int'(evt_active), 0);
    tmr_en = 1'b1;
    repeat (1100) @(negedge clk);
    chk(evt_active == 1'b0, "R10 no resume after abort", int'(evt_active), 0);

    finish_run();
  end

endmodule